// File: doc/BRIEF.md
# Parallel-to-Serial Shifter with Register-Forwarded Clock

The block accepts a parallel word and sends it out one bit at a time, together with a clock that the receiver uses to sample. The system clock runs at twice the output bit rate, so the system clock is never passed to an output. Registers produce both halves of each output clock period. A bit is launched on the output clock's falling edge. It stays unchanged through the rising edge that follows, so the receiver captures it on that rising edge.

The user asserts the load strobe for one cycle while the block is idle and enabled. The word is captured and the frame starts. `busy` stays high for the length of the frame. The frame ends with a one-cycle `done` pulse. Whenever no frame is running, or the enable input is low, the output clock stays high. This gives an idle-high clock with no glitches that the receiver can always rely on.

Top module: `ser_fwdclk`

## Requirements
- R1: When `load` is high with `en` high and `busy` low at a rising `clk` edge, the word on `din` is captured. After that edge, `busy` is 1, `sck_out` is 0 and `sdo` equals `din[7]`.
- R2: Bits leave most significant first, from index 7 down to 0. Bit `7-n` is on `sdo` during both system cycles of output clock period `n` (n = 0..7). It changes only where `sck_out` falls.
- R3: While busy, `sck_out` alternates every system clock cycle, low half first. A frame has exactly 8 output clock periods, which is 16 system cycles with `busy` high.
- R4: Whenever `busy` is 0, `sck_out` is 1.
- R5: On the edge after the high half of bit 0, `busy` falls, `sck_out` stays 1, `sdo` returns to 0 and `done` is 1 for exactly one cycle.
- R6: A `load` strobe while `busy` is 1 is ignored. The running frame keeps its original bits and timing.
- R7: When `en` is 0 at a rising edge, after that edge `sck_out` is 1, `busy` is 0, `sdo` is 0 and `done` stays 0. This aborts a running frame. A `load` with `en` low starts nothing.
- R8: A synchronous active-low reset (`rst_n` = 0) sets `sdo` to 0, `sck_out` to 1 and `busy` and `done` to 0. It restores the bit index so that the next frame starts at bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; low forces idle |
| load | input | 1 | Start strobe, captures `din` when idle |
| din | input | 8 | Parallel word to send |
| sdo | output | 1 | Serial data, MSB first |
| sck_out | output | 1 | Forwarded output clock, idle high |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
Every output comes from a register, so each result appears on the first rising edge after the stimulus that causes it. The load takes effect one edge later. Bit `7-n` then occupies the two edges numbered 2n and 2n+1 after the load edge, and `done` arrives on edge 16. The bench drives inputs and samples outputs on the falling edge of `clk`. It counts falling edges from the load and compares each sample against the bit computed by shifting the word. The same counting applies to the abort and reset cases: one edge after `en` or `rst_n` drops, the idle values must be present.

// File: rtl/ser_pkg.sv
package ser_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } ser_state_e;

    // Per-cycle commands from the controller to the datapath registers
    typedef struct packed {
        logic load;     // capture a new word, present its MSB
        logic adv;      // present the next bit
        logic clr;      // return serial data to 0
        logic sck_nxt;  // level of the output clock after this edge
    } ser_ctl_t;

    function automatic int unsigned idx_width(input int unsigned w);
        return (w <= 2) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
    import ser_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     load,
    output ser_ctl_t ctl,
    output logic     busy,
    output logic     done
);
    localparam int unsigned IDX_W = idx_width(WORD_W);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WORD_W - 1);

    ser_state_e     st_q, st_n;
    logic           ph_q, ph_n;       // 0: low half showing, 1: high half showing
    logic [IDX_W-1:0] idx_q, idx_n;
    logic           done_q, done_n;

    always_comb begin
        st_n        = st_q;
        ph_n        = ph_q;
        idx_n       = idx_q;
        done_n      = 1'b0;
        ctl         = '0;
        ctl.sck_nxt = 1'b1;
        unique case (st_q)
            ST_IDLE: begin
                if (en && load) begin
                    st_n        = ST_SHIFT;
                    ph_n        = 1'b0;
                    idx_n       = IDX_TOP;
                    ctl.load    = 1'b1;
                    ctl.sck_nxt = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (!en) begin
                    st_n    = ST_IDLE;
                    idx_n   = IDX_TOP;
                    ctl.clr = 1'b1;
                end else if (!ph_q) begin
                    ph_n        = 1'b1;
                    ctl.sck_nxt = 1'b1;
                end else if (idx_q == '0) begin
                    st_n    = ST_IDLE;
                    idx_n   = IDX_TOP;
                    ctl.clr = 1'b1;
                    done_n  = 1'b1;
                end else begin
                    ph_n        = 1'b0;
                    idx_n       = idx_q - IDX_W'(1);
                    ctl.adv     = 1'b1;
                    ctl.sck_nxt = 1'b0;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ph_q   <= 1'b0;
            idx_q  <= IDX_TOP;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            ph_q   <= ph_n;
            idx_q  <= idx_n;
            done_q <= done_n;
        end
    end

    assign busy = (st_q == ST_SHIFT);
    assign done = done_q;

endmodule

// File: rtl/ser_shreg.sv
module ser_shreg
    import ser_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ser_ctl_t          ctl,
    input  logic [WORD_W-1:0] din,
    output logic              sdo
);
    logic [WORD_W-1:0] sh_q;
    logic              sdo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            sdo_q <= 1'b0;
        end else if (ctl.load) begin
            sh_q  <= {din[WORD_W-2:0], 1'b0};
            sdo_q <= din[WORD_W-1];
        end else if (ctl.adv) begin
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            sdo_q <= sh_q[WORD_W-1];
        end else if (ctl.clr) begin
            sdo_q <= 1'b0;
        end
    end

    assign sdo = sdo_q;

endmodule

// File: rtl/ser_clkgen.sv
module ser_clkgen
    import ser_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ser_ctl_t ctl,
    output logic     sck_out
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b1;
        else        sck_q <= ctl.sck_nxt;
    end

    assign sck_out = sck_q;

endmodule

// File: rtl/ser_fwdclk.sv
module ser_fwdclk
    import ser_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    output logic              sdo,
    output logic              sck_out,
    output logic              busy,
    output logic              done
);
    ser_ctl_t ctl;

    ser_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .load(load),
        .ctl(ctl), .busy(busy), .done(done)
    );

    ser_shreg #(.WORD_W(WORD_W)) u_shreg (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .din(din), .sdo(sdo)
    );

    ser_clkgen u_clkgen (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .sck_out(sck_out)
    );

endmodule

// File: rtl/ser_fwdclk_chk.sv
module ser_fwdclk_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic sdo,
    input logic sck_out,
    input logic busy,
    input logic done
);
    // R4: idle clock level
    a_r4_idle_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_out);

    // R3: clock alternates every cycle while a frame continues
    a_r3_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || (sck_out != $past(sck_out))));

    // R2: data only moves where the output clock falls
    a_r2_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(sck_out)) |-> $stable(sdo));

    // R5: done is a single-cycle pulse outside the frame
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && sck_out) ##1 !done);

    // R7: disable forces idle on the next edge
    a_r7_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sck_out && !busy && !done && !sdo));

endmodule

bind ser_fwdclk ser_fwdclk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .sdo(sdo),
    .sck_out(sck_out), .busy(busy), .done(done)
);

// File: tb/ser_fwdclk_bench.sv
`timescale 1ns/1ps
module ser_fwdclk_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       load = 1'b0;
    logic [7:0] din = 8'h00;
    logic       sdo, sck_out, busy, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    ser_fwdclk u_ser_fwdclk (
        .clk(clk), .rst_n(rst_n), .en(en), .load(load), .din(din),
        .sdo(sdo), .sck_out(sck_out), .busy(busy), .done(done)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic idle_check(input string req);
        check(req, "sck", sck_out, 1);
        check(req, "busy", busy, 0);
        check(req, "sdo", sdo, 0);
    endtask

    // Sends word w; optionally injects a load of junk while busy (R6)
    task automatic send(input logic [7:0] w, input bit inject);
        din  = w;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        din  = ~w;
        check("R1", "busy after load", busy, 1);
        for (int n = 0; n < 8; n++) begin
            logic exp_bit;
            exp_bit = (w >> (7 - n)) & 8'h01;
            check("R3", "sck low half", sck_out, 0);
            check("R2", "bit low half", sdo, exp_bit);
            if (inject && n == 3) load = 1'b1;
            @(negedge clk);
            load = 1'b0;
            check("R3", "sck high half", sck_out, 1);
            check("R2", "bit high half", sdo, exp_bit);
            check(inject ? "R6" : "R3", "busy in frame", busy, 1);
            @(negedge clk);
        end
        check("R5", "done pulse", done, 1);
        idle_check("R5");
        @(negedge clk);
        check("R5", "done cleared", done, 0);
        check("R4", "idle sck", sck_out, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        idle_check("R8");
        check("R8", "done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: load with enable low does nothing
        din = 8'hA5; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        idle_check("R7");
        en = 1'b1;
        @(negedge clk);
        idle_check("R4");

        // R1/R2/R3/R5: sweep every word
        for (int w = 0; w < 256; w++) send(8'(w), 1'b0);

        // R6: strobe while busy
        send(8'h3C, 1'b1);
        send(8'hC3, 1'b1);

        // R7: abort mid-frame
        din = 8'hFF; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (4) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        idle_check("R7");
        check("R7", "no done", done, 0);
        @(negedge clk);
        check("R7", "no done later", done, 0);
        idle_check("R7");
        en = 1'b1;
        @(negedge clk);
        send(8'h81, 1'b0);

        // R8: reset mid-frame, next frame starts at bit 7
        din = 8'h7E; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        idle_check("R8");
        check("R8", "done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        send(8'h80, 1'b0);
        send(8'h01, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule